// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog peripheral driven through a plain 32-bit register port. Software programs a tick divider and a timeout, then enables the countdown. A free-running 1 MHz base strobe (`tick_us`, one clock wide per microsecond) is divided by the programmed prescale value to form the watchdog tick. A 16-bit down-counter loses one count per watchdog tick. To keep the system alive, software writes a restart command to the status word, which reloads the counter. If the counter runs out, the block raises a reset request pulse of fixed length and sets a sticky flag that records the watchdog as the cause of the reset.

The sticky cause flag and the reset pulse sit on a power-on reset (`por_n`). The watchdog's own system reset does not clear them, so software can read the cause after the reset. All other state sits on `rst_n`. The prescaler must not be changed while the watchdog runs. To change it safely, software disables the watchdog, writes the prescale and load values, and then enables it again. Writes to the control word replace the whole word, so software modifies it with read-modify-write. The read port is combinational, has no side effects and returns the word chosen by `addr`.

Top module: `wdog_timer`

## Requirements
- R1: Word offsets: status/restart at 0x00, control at 0x20, load at 0x24, system reset status at 0x38. Any other offset reads as zero, and writes to it change no register. After `rst_n` and `por_n`, every register reads zero and `rst_req` is low.
- R2: Control word layout: bit 7 is the enable, and bits 31:16 hold the prescale value. A write replaces both fields. All other bits read as zero.
- R3: Load word: bits 15:0 hold the timeout in watchdog ticks. Bits 31:16 read as zero.
- R4: While the watchdog is enabled, one watchdog tick occurs for every P base strobes, where P is the prescale value. A prescale value of 0 counts as 1.
- R5: A control write that changes the enable from 0 to 1 loads the counter from the load word and clears the prescale count.
- R6: A write to offset 0x00 with bit 9 set reloads the counter and clears the prescale count. Writes there with bit 9 clear have no effect. Offset 0x00 always reads zero.
- R7: With load value L, expiry happens on the max(L,1)-th watchdog tick after the last reload. `rst_req` rises in the cycle after the clock edge that samples that tick.
- R8: Each expiry drives `rst_req` high for exactly 16 clock cycles. After an expiry, no further pulse is raised until the counter is reloaded.
- R9: Clearing the enable freezes both the counter and the prescale count, and no expiry occurs. The prescale field keeps its written value.
- R10: Bit 1 of the system reset status word is set on expiry. It survives `rst_n`. Only writing 1 to that bit or asserting `por_n` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset; clears the cause flag and the pulse logic |
| rst_n | input | 1 | Active-low system reset; clears the registers and the counters |
| tick_us | input | 1 | Base strobe, one cycle high per microsecond |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 8 | Byte offset of the word accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| rst_req | output | 1 | Reset request pulse to the system reset controller |

## Verification
The countdown is run with several prescale and load pairs: (3,2), (4,1), (0,2), (1,0) and (2,3). Counting base strobes to the expiry point separates a correct divider from an off-by-one divider, and separates the treatment of a prescale of 0 and a load of 0 from the normal case. Keepalive writes are placed part-way through a countdown, with and without bit 9 set. A restart in the middle of a prescale period shows that the prescale count is cleared as well as the counter. A disable/re-enable sequence tells a frozen countdown apart from one that is reset or keeps running. A system reset applied while the cause flag is set confirms that the flag sits in its own reset domain.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_LOAD = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_SYS  = 8'h38;

  localparam int EN_BIT      = 7;
  localparam int RESTART_BIT = 9;
  localparam int PRE_LSB     = 16;
  localparam int CAUSE_BIT   = 1;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int PRE_W = 16,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cause_i,
  output logic              en_o,
  output logic [PRE_W-1:0]  pre_o,
  output logic [CNT_W-1:0]  load_o,
  output logic              load_req_o,
  output logic              cause_clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic             en_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] load_q;
  logic             wr_ctrl, wr_load, en_rise, restart;

  assign wr_ctrl     = wr_en && (addr == OFS_CTRL);
  assign wr_load     = wr_en && (addr == OFS_LOAD);
  assign en_rise     = wr_ctrl && wdata[EN_BIT] && !en_q;
  assign restart     = wr_en && (addr == OFS_STAT) && wdata[RESTART_BIT];
  assign load_req_o  = en_rise || restart;
  assign cause_clr_o = wr_en && (addr == OFS_SYS) && wdata[CAUSE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pre_q  <= '0;
      load_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata[EN_BIT];
        pre_q <= wdata[PRE_LSB +: PRE_W];
      end
      if (wr_load) load_q <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr)
      OFS_CTRL: begin
        rdata_o[PRE_LSB +: PRE_W] = pre_q;
        rdata_o[EN_BIT]           = en_q;
      end
      OFS_LOAD: rdata_o[CNT_W-1:0] = load_q;
      OFS_SYS:  rdata_o[CAUSE_BIT] = cause_i;
      default:  rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign pre_o  = pre_q;
  assign load_o = load_q;

  // R2
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (en_q == $past(wdata[EN_BIT])) && (pre_q == $past(wdata[PRE_LSB +: PRE_W])));
  // R1
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_load |=> $stable(load_q));
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic             wd_tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] eff;

  assign eff       = (pre_i == '0) ? PRE_W'(1) : pre_i;
  assign wd_tick_o = en_i && tick_i && !clr_i && (cnt_q >= eff - PRE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (en_i && tick_i)   cnt_q <= wd_tick_o ? '0 : cnt_q + PRE_W'(1);
  end

  // R9
  pre_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(cnt_q));
  // R5
  pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_req_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             wd_tick_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] count_q;
  logic             armed_q;

  assign expire_o = wd_tick_i && armed_q && !load_req_i && (count_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      armed_q <= 1'b0;
    end else if (load_req_i) begin
      count_q <= load_i;
      armed_q <= 1'b1;
    end else if (wd_tick_i) begin
      if (count_q != '0) count_q <= count_q - CNT_W'(1);
      if (expire_o)      armed_q <= 1'b0;
    end
  end

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_req_i |=> (count_q == $past(load_i)) && armed_q);
  // R8
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !armed_q);
  // R9
  count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_req_i && !wd_tick_i) |=> $stable(count_q));
endmodule

// File: rtl/wdt_cause.sv
module wdt_cause #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic expire_i,
  input  logic clr_i,
  output logic rst_req_o,
  output logic cause_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] pulse_q;
  logic          cause_q;
  logic [PW-1:0] hi_run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pulse_q <= '0;
      cause_q <= 1'b0;
    end else begin
      if (expire_i && (pulse_q == '0)) pulse_q <= PW'(PULSE_LEN);
      else if (pulse_q != '0)          pulse_q <= pulse_q - PW'(1);
      if (expire_i)   cause_q <= 1'b1;
      else if (clr_i) cause_q <= 1'b0;
    end
  end

  assign rst_req_o = (pulse_q != '0);
  assign cause_o   = cause_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         hi_run <= '0;
    else if (rst_req_o) hi_run <= hi_run + PW'(1);
    else                hi_run <= '0;
  end

  // R8
  pulse_len_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_req_o |-> (hi_run < PW'(PULSE_LEN)));
  // R10
  cause_set_chk: assert property (@(posedge clk) disable iff (!por_n)
    expire_i |=> (cause_o && rst_req_o));
  // R10
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!expire_i && !clr_i) |=> $stable(cause_o));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdt_pkg::*;
#(
  parameter int PRE_W     = 16,
  parameter int CNT_W     = 16,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rst_req
);
  logic             en, load_req, cause_clr, wd_tick, expire, cause;
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] load_val;

  wdt_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cause_i(cause), .en_o(en), .pre_o(pre), .load_o(load_val),
    .load_req_o(load_req), .cause_clr_o(cause_clr), .rdata_o(rdata)
  );

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en_i(en), .tick_i(tick_us),
    .clr_i(load_req), .pre_i(pre), .wd_tick_o(wd_tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_req_i(load_req), .load_i(load_val),
    .wd_tick_i(wd_tick), .expire_o(expire)
  );

  wdt_cause #(.PULSE_LEN(PULSE_LEN)) u_cause (
    .clk(clk), .por_n(por_n), .expire_i(expire), .clr_i(cause_clr),
    .rst_req_o(rst_req), .cause_o(cause)
  );

  // R7
  no_expire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !expire);
endmodule

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0;
  logic        tick_us = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  wdog_timer i_wdog_timer (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_us(tick_us), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_us = 1'b1;
      @(negedge clk); tick_us = 1'b0;
    end
  endtask

  task automatic cfg(input logic [15:0] p, input logic [15:0] l);
    wr(8'h20, {p, 16'h0});
    wr(8'h24, {16'h0, l});
    wr(8'h20, {p, 16'h0080});
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40 && rst_req; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 rst_req after reset", {31'b0, rst_req}, 32'd0);
    rd(8'h20, d); chk("R1 ctrl reset", d, 32'h0);
    rd(8'h24, d); chk("R1 load reset", d, 32'h0);
    rd(8'h38, d); chk("R1 sys reset", d, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(8'h20, 32'hFFFF_FF7F);
    rd(8'h20, d); chk("R2 ctrl reserved bits zero", d, 32'hFFFF_0000);
    wr(8'h24, 32'h1234_ABCD);
    rd(8'h24, d); chk("R3 load upper zero", d, 32'h0000_ABCD);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R1 unmapped reads zero", d, 32'h0);
    rd(8'h20, d); chk("R1 unmapped write no effect", d, 32'hFFFF_0000);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R6 status reads zero", d, 32'h0);
  endtask

  task automatic t_expire();
    logic [31:0] d;
    int hi;
    cfg(16'd3, 16'd2);
    ticks(5); chk("R4 R7 no expiry before P*L strobes", {31'b0, rst_req}, 32'd0);
    ticks(1); chk("R7 expiry at P*L strobes", {31'b0, rst_req}, 32'd1);
    hi = 0;
    for (int i = 0; i < 40; i++) begin
      if (rst_req) hi++;
      @(negedge clk);
    end
    chk("R8 pulse width", hi, 32'd16);
    rd(8'h38, d); chk("R10 cause set", d, 32'h2);
    ticks(8); chk("R8 single pulse per load", {31'b0, rst_req}, 32'd0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(8'h38, d); chk("R10 cause survives rst_n", d, 32'h2);
    rd(8'h20, d); chk("R1 ctrl cleared by rst_n", d, 32'h0);
    wr(8'h38, 32'hFFFF_FFFD);
    rd(8'h38, d); chk("R10 write 0 keeps cause", d, 32'h2);
    wr(8'h38, 32'h2);
    rd(8'h38, d); chk("R10 write 1 clears cause", d, 32'h0);
  endtask

  task automatic t_restart();
    cfg(16'd1, 16'd3);
    ticks(2); wr(8'h00, 32'h0000_0200);
    ticks(2); chk("R6 restart delays expiry", {31'b0, rst_req}, 32'd0);
    ticks(1); chk("R6 expiry after restart", {31'b0, rst_req}, 32'd1);
    wait_idle();
    cfg(16'd1, 16'd3);
    ticks(2); wr(8'h00, 32'hFFFF_FDFF);
    ticks(1); chk("R6 write without bit 9 no reload", {31'b0, rst_req}, 32'd1);
    wait_idle();
  endtask

  task automatic t_pre_clear();
    cfg(16'd4, 16'd1);
    ticks(3); wr(8'h00, 32'h0000_0200);
    ticks(3); chk("R6 restart clears prescale count", {31'b0, rst_req}, 32'd0);
    ticks(1); chk("R4 expiry after 4 strobes", {31'b0, rst_req}, 32'd1);
    wait_idle();
  endtask

  task automatic t_halt();
    logic [31:0] d;
    cfg(16'd2, 16'd3);
    ticks(3); wr(8'h20, 32'h0002_0000);
    ticks(10); chk("R9 disabled no expiry", {31'b0, rst_req}, 32'd0);
    rd(8'h20, d); chk("R9 prescale kept, enable clear", d, 32'h0002_0000);
    wr(8'h20, 32'h0002_0080);
    ticks(5); chk("R5 re-enable reloads", {31'b0, rst_req}, 32'd0);
    ticks(1); chk("R5 expiry after full reload", {31'b0, rst_req}, 32'd1);
    wait_idle();
  endtask

  task automatic t_zero_cases();
    cfg(16'd0, 16'd2);
    ticks(1); chk("R4 prescale 0 counts as 1", {31'b0, rst_req}, 32'd0);
    ticks(1); chk("R4 prescale 0 expiry", {31'b0, rst_req}, 32'd1);
    wait_idle();
    cfg(16'd1, 16'd0);
    ticks(1); chk("R7 load 0 expires on first tick", {31'b0, rst_req}, 32'd1);
    wait_idle();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_expire();
    t_sticky();
    t_restart();
    t_pre_clear();
    t_halt();
    t_zero_cases();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog timeout actual=%h expected=%h", 32'd1, 32'd0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule